// File: doc/BRIEF.md
# Cartridge Bank-Switching Controller

This block sits between an 8-bit CPU bus and the memories on a game cartridge. It decodes the 16-bit CPU address and keeps a single control byte. From that byte it forms the upper address lines of a program ROM paged in 32 KiB banks and of a 32 KiB work RAM seen through one 8 KiB window. It also produces the chip selects, the RAM write strobe and the read data returned to the CPU. The character-memory address always uses bank 0, and the nametable mirroring setting is passed straight through from a strap input.

Software changes the mapping by writing any byte to any address from $8000 to $FFFF. The low five bits of that byte choose the ROM bank and the top two bits choose the RAM page. Bit 5 is unused. The number of installed ROM banks is a parameter and does not have to be a power of two: a bank number past the end wraps modulo that count. A debug port shows the control byte, and a restore strobe loads the byte directly, so machine state can be saved and later put back.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write (`cpu_en`=1, `cpu_we`=1) to any address from $8000 to $FFFF stores the whole data byte in the control register. The new value appears on `dbg_ctrl` in the cycle after the clock edge. With no such write and no restore, the register keeps its value.
- R2: `rom_addr` is the selected bank, taken from control bits 4:0, placed above CPU A14:A0. `rom_ce` is high exactly for CPU reads in $8000–$FFFF.
- R3: When the bank number in bits 4:0 is at or above ROM_BANKS, the bank placed on `rom_addr` is that number modulo ROM_BANKS.
- R4: Control bits 7:6 select the RAM page. For accesses in $6000–$7FFF, `ram_addr` = page×8192 + (address − $6000) and `ram_ce` is high. Each page keeps its own contents while the other pages are selected.
- R5: `ram_we` is high only for CPU writes in $6000–$7FFF. A CPU write in $8000–$FFFF never raises `rom_ce`.
- R6: Control bit 5 does not change `rom_addr` or `ram_addr`.
- R7: `chr_addr` is `ppu_addr` with its bank bits held at zero, whatever the control register holds.
- R8: After reset the control register is 0, so ROM bank 0 and RAM page 0 are mapped.
- R9: `mirror_out` always equals `mirror_cfg`. Register writes never change it.
- R10: A CPU access below $6000 raises neither chip select, and `cpu_rdata` is 0.
- R11: A pulse on `restore_stb` loads `restore_data` into the control register, and restore wins over a bus write in the same cycle. From the next cycle on, the new ROM bank and RAM page are in effect.
- R12: For reads, `cpu_rdata` returns `rom_rdata` in $8000–$FFFF and `ram_rdata` in $6000–$7FFF. For writes it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | ROM_AW | Program ROM address (bank, A14:A0) |
| rom_ce | output | 1 | Program ROM chip select |
| rom_rdata | input | 8 | Program ROM data |
| ram_addr | output | RAM_AW | Work RAM address (page, A12:A0) |
| ram_ce | output | 1 | Work RAM chip select |
| ram_we | output | 1 | Work RAM write enable |
| ram_rdata | input | 8 | Work RAM data |
| ppu_addr | input | 13 | Character-memory address from the video side |
| chr_addr | output | CHR_AW | Character ROM address, bank fixed at 0 |
| mirror_cfg | input | 1 | Mirroring strap |
| mirror_out | output | 1 | Mirroring passed through |
| dbg_ctrl | output | 8 | Control register readback |
| restore_stb | input | 1 | Load control register from restore_data |
| restore_data | input | 8 | Value to restore |

## Verification
The assertions assume that `cpu_en`, `cpu_we`, `cpu_addr` and the restore inputs are known (never X) at every rising edge after reset. They also assume those inputs change only between edges. The bench meets both assumptions: it drives every input on the falling edge and starts from defined values at time zero. It overlaps restore pulses with register writes only when it is checking the priority rule. The reference model treats the ROM as data that encodes its bank number and the RAM as a 32 KiB array. As a result, a wrong wrap or a wrong page shows up both on the address lines and in the data returned to the CPU.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANKS  = 11,
  parameter int ROM_SEL_W  = 5,
  parameter int RAM_SEL_W  = 2,
  parameter int CHR_BANK_W = 3,
  localparam int CTRL_W     = 8,
  localparam int ROM_BANK_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW     = ROM_BANK_W + 15,
  localparam int RAM_AW     = RAM_SEL_W + 13,
  localparam int CHR_AW     = CHR_BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce,
  input  logic [7:0]        rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata,
  input  logic [12:0]       ppu_addr,
  output logic [CHR_AW-1:0] chr_addr,
  input  logic              mirror_cfg,
  output logic              mirror_out,
  output logic [7:0]        dbg_ctrl,
  input  logic              restore_stb,
  input  logic [7:0]        restore_data
);

  logic [CTRL_W-1:0]     ctrl;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_SEL_W-1:0]  ram_page;
  logic                  hit_rom, hit_ram, reg_wr;

  assign hit_rom = cpu_en && cpu_addr[15];
  assign hit_ram = cpu_en && (cpu_addr[15:13] == 3'b011);
  assign reg_wr  = hit_rom && cpu_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl <= '0;
    else if (restore_stb) ctrl <= restore_data;
    else if (reg_wr)      ctrl <= cpu_wdata;
  end

  always_comb rom_bank = ROM_BANK_W'(int'(ctrl[ROM_SEL_W-1:0]) % ROM_BANKS);
  assign ram_page = ctrl[CTRL_W-1 -: RAM_SEL_W];

  assign rom_addr   = {rom_bank, cpu_addr[14:0]};
  assign ram_addr   = {ram_page, cpu_addr[12:0]};
  assign chr_addr   = {{CHR_BANK_W{1'b0}}, ppu_addr};
  assign rom_ce     = hit_rom && !cpu_we;
  assign ram_ce     = hit_ram;
  assign ram_we     = hit_ram && cpu_we;
  assign mirror_out = mirror_cfg;
  assign dbg_ctrl   = ctrl;

  always_comb begin
    cpu_rdata = '0;
    if (rom_ce)                cpu_rdata = rom_rdata;
    else if (ram_ce && !cpu_we) cpu_rdata = ram_rdata;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_we && cpu_addr[15] && !restore_stb) |=> (dbg_ctrl == $past(cpu_wdata)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_en && cpu_we && cpu_addr[15]) && !restore_stb) |=> $stable(dbg_ctrl));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr[ROM_AW-1:15] < ROM_AW'(ROM_BANKS)) || (ROM_BANKS >= (1 << ROM_BANK_W)));

  assert_no_rom_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_we) |-> !rom_ce);

  assert_low_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_addr < 16'h6000) |-> (!rom_ce && !ram_ce && !ram_we && cpu_rdata == 8'h00));

  assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb |=> (dbg_ctrl == $past(restore_data)));

endmodule

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
  localparam int NB = 11;

  logic clk = 0, rst_n = 0;
  logic cpu_en = 0, cpu_we = 0, mirror_cfg = 0, restore_stb = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, restore_data = 0;
  logic [12:0] ppu_addr = 0;
  logic [7:0]  cpu_rdata, rom_rdata, ram_rdata, dbg_ctrl;
  logic [18:0] rom_addr;
  logic [14:0] ram_addr;
  logic [15:0] chr_addr;
  logic rom_ce, ram_ce, ram_we, mirror_out;

  int checks = 0, fails = 0;
  int ref_ctrl = 0;
  byte unsigned ref_mem [32768];
  logic [7:0] mem [32768];

  always #2.5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(NB)) u0 (
    .clk, .rst_n, .cpu_en, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .rom_addr, .rom_ce, .rom_rdata, .ram_addr, .ram_ce, .ram_we, .ram_rdata,
    .ppu_addr, .chr_addr, .mirror_cfg, .mirror_out, .dbg_ctrl,
    .restore_stb, .restore_data);

  assign rom_rdata = {rom_addr[18:15], rom_addr[3:0]};
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= cpu_wdata;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(bit en, bit we, int addr, int data, bit rs = 0, int rd = 0);
    int bank, page, ridx, exp_rd;
    bit hrom, hram;
    @(negedge clk);
    cpu_en = en; cpu_we = we; cpu_addr = 16'(addr); cpu_wdata = 8'(data);
    restore_stb = rs; restore_data = 8'(rd);
    ppu_addr = 13'($urandom); mirror_cfg = 1'($urandom);
    #1;
    hrom = en && addr >= 'h8000;
    hram = en && addr >= 'h6000 && addr < 'h8000;
    bank = (ref_ctrl & 31) % NB;
    page = (ref_ctrl >> 6) & 3;
    ridx = page * 8192 + (addr & 'h1FFF);
    exp_rd = 0;
    if (!we && hrom) exp_rd = ((bank & 15) << 4) | (addr & 15);
    if (!we && hram) exp_rd = ref_mem[ridx];
    check("R1/R8/R11 dbg_ctrl", dbg_ctrl, ref_ctrl);
    check("R2/R3/R6 rom_addr", rom_addr, bank * 32768 + (addr & 'h7FFF));
    check("R2/R5/R10 rom_ce", rom_ce, hrom && !we);
    check("R4/R6 ram_addr", ram_addr, page * 8192 + (addr & 'h1FFF));
    check("R4/R10 ram_ce", ram_ce, hram);
    check("R5 ram_we", ram_we, hram && we);
    check("R12/R10 cpu_rdata", cpu_rdata, exp_rd);
    check("R7 chr_addr", chr_addr, ppu_addr);
    check("R9 mirror_out", mirror_out, mirror_cfg);
    if (hram && we) ref_mem[ridx] = 8'(data);
    if (rs) ref_ctrl = rd & 255;
    else if (hrom && we) ref_ctrl = data & 255;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (ref_mem[i]) begin ref_mem[i] = 0; mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    op(1, 0, 'h8000, 0);                 // R8 reset state
    op(1, 0, 'hC123, 0);
    op(1, 1, 'h8000, 'h03); op(1, 0, 'h8000, 0); // R2
    op(1, 1, 'hFFFF, 'h05); op(1, 0, 'hABCD, 0); // R1 any address
    op(1, 1, 'h9000, 'h23); op(1, 0, 'h8004, 0); // R6 bit 5
    op(1, 1, 'h8000, 'hC3); op(1, 0, 'h6001, 0); // R6 page and bank
    op(1, 1, 'h8000, 'h0B); op(1, 0, 'h8000, 0); // R3 11 -> 0
    op(1, 1, 'h8000, 'h1F); op(1, 0, 'hFFFF, 0); // R3 31 -> 9
    op(1, 1, 'h8000, 'h10); op(1, 0, 'h8002, 0); // R3 16 -> 5
    for (int p = 0; p < 4; p++) begin            // R4 pages
      op(1, 1, 'h8000, p << 6);
      op(1, 1, 'h6000, 'hA0 + p);
      op(1, 1, 'h7FFF, 'hB0 + p);
    end
    for (int p = 3; p >= 0; p--) begin
      op(1, 1, 'h8000, p << 6);
      op(1, 0, 'h6000, 0);
      op(1, 0, 'h7FFF, 0);
    end
    op(1, 0, 'h1234, 0); op(1, 1, 'h5FFF, 'h77); op(1, 0, 'h5FFF, 0); // R10
    op(0, 1, 'h8000, 'hFF); op(0, 0, 'h6000, 0);
    op(1, 0, 'h4000, 0, 1, 'hC5); op(1, 0, 'h8000, 0); op(1, 0, 'h6000, 0); // R11
    op(1, 1, 'h8000, 'h01, 1, 'h47); op(1, 0, 'h8000, 0);                 // R11 priority
    for (int i = 0; i < 2000; i++)
      op(1'($urandom), 1'($urandom), int'($urandom) & 'hFFFF, int'($urandom) & 255,
         ($urandom % 40) == 0, int'($urandom) & 255);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule